// File: doc/BRIEF.md
# Sequential Multiply and Divide Unit

This unit performs one multiply or divide at a time, signed or unsigned, at two sizes. In byte size it multiplies 8 by 8 bits into a 16-bit product, or divides a 16-bit dividend by an 8-bit divisor. In word size it multiplies 16 by 16 bits into a 32-bit product, or divides a 32-bit dividend by a 16-bit divisor. A divide packs remainder and quotient into the two halves of one destination-sized result.

The client places the destination operand on `dst_i` and the source operand on `src_i`, selects the operation, signedness and size, and pulses `start_i`. The unit takes a snapshot of the inputs and runs a radix-2 iterative engine on operand magnitudes. It then applies signs and presents the result after a latency that depends only on the mode. Multiplier and dividend come from `dst_i`, and multiplicand and divisor come from `src_i`.

Top module: `md_unit`

## Requirements
- R1: Byte multiply (`div_i`=0, `word_i`=0) multiplies dst_i[7:0] by src_i[7:0]. result_o[15:0] holds the product, and result_o[31:16] copies dst_i[31:16].
- R2: Word multiply (`div_i`=0, `word_i`=1) multiplies dst_i[15:0] by src_i[15:0] and puts the 32-bit product on result_o.
- R3: Byte divide (`div_i`=1, `word_i`=0) divides dst_i[15:0] by src_i[7:0]. The quotient goes to result_o[7:0], the remainder to result_o[15:8], and result_o[31:16] copies dst_i[31:16]. Quotient and remainder are defined when the quotient magnitude is below 256.
- R4: Word divide (`div_i`=1, `word_i`=1) divides dst_i[31:0] by src_i[15:0]. The quotient goes to result_o[15:0] and the remainder to result_o[31:16]. They are defined when the quotient magnitude is below 65536.
- R5: With `sgn_i`=1, operands are two's complement. The quotient rounds toward zero, the remainder carries the dividend's sign, and each result field holds the low bits of the exact value.
- R6: `done_o` rises on the Lth rising edge after the edge that accepts `start_i`. L is 12 for unsigned byte, 20 for unsigned word, 13 for signed byte and 21 for signed word. `busy_o` is high from the accepting edge until that edge, and is never high together with `done_o`.
- R7: `done_o` is high for exactly one cycle. `result_o` and the flags change only at the edge that raises `done_o`, and they hold until the next completion.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes with its own operands and latency, and no second completion follows.
- R9: A divide by a zero divisor completes at the normal latency. It puts the unchanged dst_i snapshot on result_o, with `flag_z_o`=1 and `flag_n_o`=0.
- R10: A divide with a non-zero divisor gives `flag_z_o`=0. `flag_n_o` is the divisor's top bit (bit 7 or 15) when unsigned, and the quotient field's top bit when signed.
- R11: A multiply gives `flag_n_o` = the top bit of the product at its size (bit 15 or 31) and `flag_z_o` = 1 when the product at its size is zero.
- R12: After reset, busy_o, done_o, result_o, flag_n_o and flag_z_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation |
| div_i | input | 1 | 1 = divide, 0 = multiply |
| sgn_i | input | 1 | 1 = signed operands |
| word_i | input | 1 | 1 = word size, 0 = byte size |
| dst_i | input | 32 | Destination operand: multiplier or dividend, upper part passed through in byte size |
| src_i | input | 16 | Source operand: multiplicand or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Packed product, or remainder and quotient |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
Each of the four size and operation combinations is swept in both signedness modes over an operand set. The set combines sign-boundary values (0, 1, 0x7F, 0x80, 0xFF and neighbours) with spread values. Unsigned and signed runs on the same bit patterns show whether the magnitude conversion and sign restoration are applied only when asked. The boundary values expose a missing carry or an off-by-one in the iteration count. Divide dividends are built as quotient times divisor plus a remainder of the dividend's sign, so most cases fall inside the defined range and they probe the truncation direction and the remainder sign. Zero divisors and a start pulse during a busy operation are exercised separately. Junk in the unused upper operand bits must not disturb byte results.

// File: rtl/md_pkg.sv
package md_pkg;

  typedef struct packed {
    logic div;
    logic sgn;
    logic word;
  } md_mode_t;

  function automatic int unsigned md_latency(input logic sgn, input logic word,
                                             input int unsigned lat_b,
                                             input int unsigned lat_w,
                                             input int unsigned lat_sx);
    int unsigned l;
    l = word ? lat_w : lat_b;
    if (sgn) l = l + lat_sx;
    return l;
  endfunction

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl #(
  parameter int unsigned LAT_UB = 12,
  parameter int unsigned LAT_UW = 20,
  parameter int unsigned LAT_SX = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sgn_i,
  input  logic word_i,
  output logic accept_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);
  import md_pkg::*;

  localparam int unsigned LMAX = ((LAT_UB > LAT_UW) ? LAT_UB : LAT_UW) + LAT_SX;
  localparam int unsigned CW   = $clog2(LMAX + 1);

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          accept;

  assign accept = start_i & ~busy_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    done_n = busy_q & (cnt_q == '0);
    if (accept) begin
      busy_n = 1'b1;
      cnt_n  = CW'(md_latency(sgn_i, word_i, LAT_UB, LAT_UW, LAT_SX) - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
    end
  end

  assign accept_o = accept;
  assign fin_o    = busy_q & (cnt_q == '0);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  // Checker support: cycles since acceptance and the latency promised then.
  logic [CW-1:0] age_q;
  logic [CW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      lat_q <= '0;
    end else if (accept) begin
      age_q <= '0;
      lat_q <= CW'(md_latency(sgn_i, word_i, LAT_UB, LAT_UW, LAT_SX));
    end else if (busy_q) begin
      age_q <= age_q + 1'b1;
    end
  end

  // R6: completion lands exactly at the latency of the accepted mode
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (age_q == lat_q));

  // R6: busy and done never overlap
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/md_iter.sv
module md_iter #(
  parameter int unsigned BW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              div_i,
  input  logic              word_i,
  input  logic [4*BW-1:0]   num_i,
  input  logic [2*BW-1:0]   den_i,
  output logic [4*BW-1:0]   acc_o,
  output logic              idle_o
);
  localparam int unsigned WW  = 2 * BW;
  localparam int unsigned DW  = 4 * BW;
  localparam int unsigned SCW = $clog2(WW + 1);

  logic [DW-1:0]  acc_q, acc_n;
  logic [DW-1:0]  aux_q, aux_n;
  logic [WW-1:0]  mpl_q, mpl_n;
  logic [SCW-1:0] step_q, step_n;
  logic           div_q, div_n;
  logic [DW:0]    sh;
  logic [WW:0]    top;
  logic [WW-1:0]  diff;

  always_comb begin
    acc_n  = acc_q;
    aux_n  = aux_q;
    mpl_n  = mpl_q;
    step_n = step_q;
    div_n  = div_q;
    sh     = {acc_q, 1'b0};
    top    = sh[DW:WW];
    diff   = top[WW-1:0] - aux_q[WW-1:0];
    if (load_i) begin
      div_n  = div_i;
      step_n = word_i ? SCW'(WW) : SCW'(BW);
      if (div_i) begin
        acc_n = word_i ? num_i : (num_i << BW);
        aux_n = DW'(den_i);
        mpl_n = '0;
      end else begin
        acc_n = '0;
        aux_n = num_i;
        mpl_n = den_i;
      end
    end else if (step_q != '0) begin
      step_n = step_q - 1'b1;
      if (div_q) begin
        if (top >= {1'b0, aux_q[WW-1:0]}) acc_n = {diff, sh[WW-1:1], 1'b1};
        else                              acc_n = sh[DW-1:0];
      end else begin
        if (mpl_q[0]) acc_n = acc_q + aux_q;
        aux_n = aux_q << 1;
        mpl_n = mpl_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      aux_q  <= '0;
      mpl_q  <= '0;
      step_q <= '0;
      div_q  <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      aux_q  <= aux_n;
      mpl_q  <= mpl_n;
      step_q <= step_n;
      div_q  <= div_n;
    end
  end

  assign acc_o  = acc_q;
  assign idle_o = (step_q == '0);

  // R6: the iteration count never exceeds one step per result bit
  p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= SCW'(WW));

endmodule

// File: rtl/md_unit.sv
module md_unit #(
  parameter int unsigned BW     = 8,
  parameter int unsigned LAT_UB = 12,
  parameter int unsigned LAT_UW = 20,
  parameter int unsigned LAT_SX = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            div_i,
  input  logic            sgn_i,
  input  logic            word_i,
  input  logic [4*BW-1:0] dst_i,
  input  logic [2*BW-1:0] src_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [4*BW-1:0] result_o,
  output logic            flag_n_o,
  output logic            flag_z_o
);
  import md_pkg::*;

  localparam int unsigned WW = 2 * BW;
  localparam int unsigned DW = 4 * BW;

  logic           accept, fin, idle;
  logic [DW-1:0]  acc;

  // Operand magnitudes taken straight from the ports at acceptance.
  logic           xs, ys;
  logic [DW-1:0]  xext, xmag;
  logic [WW-1:0]  yext, ymag;

  always_comb begin
    if (word_i) begin
      ys   = sgn_i & src_i[WW-1];
      yext = src_i;
    end else begin
      ys   = sgn_i & src_i[BW-1];
      yext = {{BW{ys}}, src_i[BW-1:0]};
    end
    ymag = ys ? (~yext + 1'b1) : yext;
    case ({div_i, word_i})
      2'b00: begin
        xs   = sgn_i & dst_i[BW-1];
        xext = {{(DW-BW){xs}}, dst_i[BW-1:0]};
      end
      2'b11: begin
        xs   = sgn_i & dst_i[DW-1];
        xext = dst_i;
      end
      default: begin
        xs   = sgn_i & dst_i[WW-1];
        xext = {{WW{xs}}, dst_i[WW-1:0]};
      end
    endcase
    xmag = xs ? (~xext + 1'b1) : xext;
  end

  md_ctrl #(.LAT_UB(LAT_UB), .LAT_UW(LAT_UW), .LAT_SX(LAT_SX)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sgn_i(sgn_i), .word_i(word_i),
    .accept_o(accept), .fin_o(fin), .busy_o(busy_o), .done_o(done_o)
  );

  md_iter #(.BW(BW)) iter_i (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .div_i(div_i), .word_i(word_i),
    .num_i(xmag), .den_i(ymag), .acc_o(acc), .idle_o(idle)
  );

  // Snapshot of the request.
  md_mode_t       mode_q;
  logic [DW-1:0]  dst_q;
  logic [WW-1:0]  src_q;
  logic           nega_q, negr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dst_q  <= '0;
      src_q  <= '0;
      nega_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (accept) begin
      mode_q <= '{div: div_i, sgn: sgn_i, word: word_i};
      dst_q  <= dst_i;
      src_q  <= src_i;
      nega_q <= xs ^ ys;
      negr_q <= xs;
    end
  end

  // Sign restoration and packing.
  logic           src_zero;
  logic [DW-1:0]  prod;
  logic [WW-1:0]  qm, rm, qv, rv;
  logic [DW-1:0]  res_n;
  logic           n_n, z_n;

  always_comb begin
    src_zero = mode_q.word ? (src_q == '0) : (src_q[BW-1:0] == '0);
    prod     = nega_q ? (~acc + 1'b1) : acc;
    if (mode_q.word) qm = acc[WW-1:0];
    else             qm = {{BW{1'b0}}, acc[BW-1:0]};
    rm       = acc[DW-1:WW];
    qv       = nega_q ? (~qm + 1'b1) : qm;
    rv       = negr_q ? (~rm + 1'b1) : rm;
    if (!mode_q.div) begin
      if (mode_q.word) begin
        res_n = prod;
        n_n   = prod[DW-1];
        z_n   = (prod == '0);
      end else begin
        res_n = {dst_q[DW-1:WW], prod[WW-1:0]};
        n_n   = prod[WW-1];
        z_n   = (prod[WW-1:0] == '0);
      end
    end else if (src_zero) begin
      res_n = dst_q;
      n_n   = 1'b0;
      z_n   = 1'b1;
    end else begin
      z_n = 1'b0;
      if (mode_q.word) begin
        res_n = {rv, qv};
        n_n   = mode_q.sgn ? qv[WW-1] : src_q[WW-1];
      end else begin
        res_n = {dst_q[DW-1:WW], rv[BW-1:0], qv[BW-1:0]};
        n_n   = mode_q.sgn ? qv[BW-1] : src_q[BW-1];
      end
    end
  end

  logic [DW-1:0] res_q;
  logic          n_q, z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else if (fin) begin
      res_q <= res_n;
      n_q   <= n_n;
      z_q   <= z_n;
    end
  end

  assign result_o = res_q;
  assign flag_n_o = n_q;
  assign flag_z_o = z_q;

  // R6: the engine has finished all steps before the result is taken
  p_fin_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> idle);

  // R8: a start during an operation leaves the snapshot alone
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(dst_q) && $stable(src_q) && $stable(mode_q)));

  // R9: zero divisor returns the destination untouched with Z set
  p_zero_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q.div && src_zero) |-> (result_o == dst_q && flag_z_o && !flag_n_o));

  // R7: outputs hold outside completion
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(result_o) && $stable(flag_n_o) && $stable(flag_z_o)));

endmodule

// File: tb/md_unit_tb.sv
module md_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        div_i = 1'b0;
  logic        sgn_i = 1'b0;
  logic        word_i = 1'b0;
  logic [31:0] dst_i = '0;
  logic [15:0] src_i = '0;
  logic        busy_o, done_o, flag_n_o, flag_z_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  md_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i), .sgn_i(sgn_i),
    .word_i(word_i), .dst_i(dst_i), .src_i(src_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pick8(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'h81;  7: return 8'hFE;
      8: return 8'hFF;  9: return 8'h40; 10: return 8'h55; 11: return 8'hAA;
      12: return 8'h0F; 13: return 8'hF0; 14: return 8'h7E; 15: return 8'h10;
      default: return 8'((i * 53 + 11) & 255);
    endcase
  endfunction

  function automatic longint ext(input longint v, input int bits, input bit s);
    longint m;
    m = (longint'(1) << bits) - 1;
    v = v & m;
    if (s && v[bits-1]) v = v - (longint'(1) << bits);
    return v;
  endfunction

  // Expected result from the requirements (R1-style arithmetic per mode).
  task automatic model(input bit dv, input bit sg, input bit wd, input logic [31:0] d,
                       input logic [15:0] s, output logic [31:0] er, output bit en,
                       output bit ez, output bit valid);
    longint a, b, p, q, r;
    logic [63:0] pv, qv, rv;
    int nb;
    nb = wd ? 16 : 8;
    valid = 1'b1;
    if (!dv) begin
      a = ext(longint'(d), nb, sg);
      b = ext(longint'(s), nb, sg);
      p = a * b;
      pv = p;
      if (wd) begin er = pv[31:0]; en = pv[31]; ez = (pv[31:0] == 0); end
      else    begin er = {d[31:16], pv[15:0]}; en = pv[15]; ez = (pv[15:0] == 0); end
    end else begin
      a = ext(longint'(d), 2 * nb, sg);
      b = ext(longint'(s), nb, sg);
      if (b == 0) begin
        er = d; en = 1'b0; ez = 1'b1;
      end else begin
        q = a / b;
        r = a % b;
        qv = q; rv = r;
        valid = ((q < 0) ? -q : q) < (longint'(1) << nb);
        ez = 1'b0;
        if (wd) begin
          er = {rv[15:0], qv[15:0]};
          en = sg ? qv[15] : s[15];
        end else begin
          er = {d[31:16], rv[7:0], qv[7:0]};
          en = sg ? qv[7] : s[7];
        end
      end
    end
  endtask

  task automatic run_op(input bit dv, input bit sg, input bit wd,
                        input logic [31:0] d, input logic [15:0] s);
    logic [31:0] er;
    bit en, ez, valid;
    int n, lat;
    string tg;
    model(dv, sg, wd, d, s, er, en, ez, valid);
    lat = (wd ? 20 : 12) + (sg ? 1 : 0);
    @(negedge clk);
    div_i = dv; sgn_i = sg; word_i = wd; dst_i = d; src_i = s; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    dst_i = ~d; src_i = ~s;
    n = 0;
    while (!done_o && n < 60) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk(n == lat && !busy_o, "R6 latency", n, lat);
    if (valid) begin
      if (!dv) tg = wd ? "R2 word product" : "R1 byte product";
      else if (s == 16'h0 || (!wd && s[7:0] == 8'h0)) tg = "R9 zero divisor";
      else tg = wd ? (sg ? "R5 R4 signed word divide" : "R4 word divide")
                   : (sg ? "R5 R3 signed byte divide" : "R3 byte divide");
      chk(result_o == er, tg, result_o, er);
      chk(flag_n_o == en && flag_z_o == ez, dv ? "R10 R9 divide flags" : "R11 multiply flags",
          {flag_n_o, flag_z_o}, {en, ez});
    end
    @(negedge clk);
    chk(!done_o, "R7 single done pulse", done_o, 0);
  endtask

  initial begin
    logic [31:0] dd;
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && result_o == 0 && flag_n_o == 0 && flag_z_o == 0,
        "R12 reset state", {busy_o, done_o, flag_n_o, flag_z_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Byte sweeps (R1, R3, R5).
    for (int sg = 0; sg < 2; sg++) begin
      for (int i = 0; i < 32; i++) begin
        for (int j = 0; j < 32; j++) begin
          longint qs, ds, base, r0;
          run_op(1'b0, sg[0], 1'b0, {16'hA5C3, 8'h3C, pick8(i)}, {8'h5A, pick8(j)});
          qs = ext(longint'(pick8(i)), 8, sg[0]);
          ds = ext(longint'(pick8(j)), 8, sg[0]);
          base = qs * ds;
          r0 = (ds == 0) ? 0 : (i % ((ds < 0) ? -ds : ds));
          base = (base >= 0) ? base + r0 : base - r0;
          dd = 32'(base);
          run_op(1'b1, sg[0], 1'b0, {16'h3C96, dd[15:0]}, {8'hC3, pick8(j)});
        end
      end
    end

    // Word sweeps (R2, R4, R5).
    for (int sg = 0; sg < 2; sg++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          logic [15:0] a16, b16;
          longint qs, ds, base, r0;
          a16 = {pick8(i), pick8(31 - i)};
          b16 = {pick8(j), pick8(20 + j)};
          run_op(1'b0, sg[0], 1'b1, {16'h9966, a16}, b16);
          qs = ext(longint'(a16), 16, sg[0]);
          ds = ext(longint'(b16), 16, sg[0]);
          base = qs * ds;
          r0 = (ds == 0) ? 0 : ((i * 977) % ((ds < 0) ? -ds : ds));
          base = (base >= 0) ? base + r0 : base - r0;
          dd = 32'(base);
          run_op(1'b1, sg[0], 1'b1, dd, b16);
        end
      end
    end

    // Zero divisors in each mode (R9).
    run_op(1'b1, 1'b0, 1'b1, 32'hDEAD_BEEF, 16'h0000);
    run_op(1'b1, 1'b1, 1'b0, 32'h1234_8001, 16'hFF00);

    // Start while busy is ignored (R8).
    @(negedge clk);
    div_i = 1'b0; sgn_i = 1'b0; word_i = 1'b0; dst_i = 32'h0000_000C; src_i = 16'h000D;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    div_i = 1'b1; sgn_i = 1'b1; word_i = 1'b1; dst_i = 32'h7777_7777; src_i = 16'h0003;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    begin
      int n;
      n = 5;
      while (!done_o && n < 60) begin
        @(posedge clk);
        n++;
        @(negedge clk);
      end
      chk(n == 12, "R8 busy start ignored latency", n, 12);
    end
    chk(result_o == 32'h0000_009C, "R8 busy start ignored result", result_o, 32'h9C);
    keep = result_o;
    begin
      bit extra;
      extra = 1'b0;
      repeat (30) begin
        @(negedge clk);
        if (done_o || busy_o) extra = 1'b1;
      end
      chk(!extra && result_o == keep, "R8 no second completion", result_o, keep);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule